// File: doc/BRIEF.md
# Byte-Wide Synchronous Serial Port

This block sits on a simple processor bus and moves bytes to and from a serial line. A byte written by the host goes into a four-entry transmit queue. A serializer then takes bytes from that queue and sends them out one bit at a time, most significant bit first. The serial clock it drives runs at half the bus clock rate. A frame-start pulse marks the first bit of every byte. An active-low enable is low while the data line carries valid bits. When several bytes are queued they go out in consecutive frames with no idle gap between them.

The receive side uses the incoming serial clock, frame-start and data lines. It rebuilds each byte and places it into a four-entry receive queue, where the host reads it. An interrupt output is raised while the transmit queue is full. The serial input clock is assumed to be already aligned with the bus clock, so the block has no synchronizers. The bench drives the port in external loopback, with each serial output wired to its matching input.

Top module: `sserial_port`

## Requirements
- R1: While `clr_n` is low at a rising bus clock edge, the block is cleared. `sclk_out`, `fs_out`, `txd` and `host_rdata` become 0, `txd_oe_n` becomes 1 and `tx_full_irq` becomes 0.
- R2: After the clear is released, `sclk_out` inverts on every bus clock edge, so its period is two bus clocks.
- R3: A byte is sent most significant bit first, one bit per `sclk_out` period. `txd` changes only on the bus edge where `sclk_out` rises, and it holds its value through the falling edge that follows.
- R4: `fs_out` is high for exactly one bit period (two bus clocks), together with the first bit of each byte, and it is never high at any other time.
- R5: `txd_oe_n` is 0 exactly while the bits of a byte are on `txd`. While it is 1, both `txd` and `fs_out` are 0.
- R6: When further bytes are queued, the next frame starts on the `sclk_out` rise right after the last bit of the current byte. Frame starts are therefore exactly 16 bus clocks apart.
- R7: A bus cycle with `host_sel`=1 and `host_wr`=1 writes `host_wdata` into the 4-entry transmit queue. `tx_full_irq` is 1 exactly while that queue holds 4 bytes. A write to a full queue is discarded and that byte is never sent.
- R8: On the receive side, bits are sampled from `rxd` on the falling edge of `sclk_in`. A sample taken while `fs_in`=1 is the most significant bit of a new byte. After 8 samples the byte is put into the receive queue. A bus cycle with `host_sel`=1 and `host_wr`=0 takes the oldest byte, which appears on `host_rdata` after that clock edge.
- R9: A read while the receive queue is empty changes nothing, and `host_rdata` keeps its previous value.
- R10: The receive queue holds 4 bytes. A byte completed while it is full is discarded, and the 4 stored bytes are still returned in order.
- R11: While `host_sel`=0, `host_wr` and `host_wdata` have no effect: nothing is queued or sent and `host_rdata` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| clr_n | input | 1 | Synchronous clear, active low |
| host_sel | input | 1 | Bus access select |
| host_wr | input | 1 | 1 = write to transmit queue, 0 = read from receive queue |
| host_wdata | input | 8 | Byte to transmit |
| host_rdata | output | 8 | Last byte read from the receive queue |
| tx_full_irq | output | 1 | High while the transmit queue is full |
| sclk_out | output | 1 | Serial clock at half the bus rate |
| fs_out | output | 1 | Frame start, high during the first bit of a byte |
| txd_oe_n | output | 1 | Low while txd carries valid data |
| txd | output | 1 | Serial transmit data |
| sclk_in | input | 1 | Incoming serial clock, aligned with clk |
| fs_in | input | 1 | Incoming frame start |
| rxd | input | 1 | Serial receive data |

## Verification
Bytes with the top bit set, bytes with only the bottom bit set, and all-ones bytes show a reversed bit order or a bit shifted by one place, because the byte read back or decoded from the line then differs. A burst of five writes while a byte is on the line fills the transmit queue. It checks that the interrupt rises at four entries, that the fifth byte is never sent, and that the frames follow one another 16 clocks apart with no idle bit period. The same burst overflows the receive queue, so a design that overwrote the oldest byte, or popped past empty, would return the wrong fourth or fifth read. A line monitor checks on every cycle that the enable, frame pulse and data change only on the rising serial clock edge.

// File: rtl/sserial_pkg.sv
// Shared definitions for the serial port.
// Assumes: nothing beyond the types declared here.
package sserial_pkg;

    // Serializer mode: idle line or shifting a byte out.
    typedef enum logic {
        TXS_IDLE  = 1'b0,
        TXS_SHIFT = 1'b1
    } txs_mode_t;

endpackage

// File: rtl/ss_fifo.sv
// Synchronous queue of DEPTH words of W bits.
// Push is ignored when full and pop is ignored when empty. The head word is
// shown combinationally. Assumes a single clock and a synchronous active-low clear.
module ss_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  store [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = store[rptr];

    // Write the accepted word into the slot at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) begin
            store[wptr] <= push_data;
        end
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            end
            if (do_pop) begin
                rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R7 / R10: a push into a full queue without a pop leaves it full.
    a_r7_full_no_grow: assert property (@(posedge clk) disable iff (!clr_n)
        (full && push && !pop) |=> full);

    // R9: a pop from an empty queue without a push leaves it empty.
    a_r9_empty_hold: assert property (@(posedge clk) disable iff (!clr_n)
        (empty && pop && !push) |=> empty);

endmodule

// File: rtl/ss_tx.sv
// Serializer. On each rise slot it shifts out the next bit, MSB first.
// After the last bit it loads the next queued byte at once, so frames run
// back to back. A frame pulse goes with the first bit, and the enable is low
// while bits are driven. Assumes rise_slot is high on the bus cycles where
// the serial clock goes from low to high.
module ss_tx
    import sserial_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         rise_slot,
    input  logic         have_data,
    input  logic [W-1:0] byte_in,
    output logic         take,
    output logic         txd,
    output logic         fs,
    output logic         oe_n
);
    localparam int BW = (W > 1) ? $clog2(W) : 1;
    localparam logic [BW-1:0] LASTBIT = BW'(W - 1);

    txs_mode_t     mode;
    logic [W-1:0]  shreg;
    logic [BW-1:0] bitcnt;
    logic          at_end, load_ok;

    assign at_end  = (mode == TXS_IDLE) || (bitcnt == LASTBIT);
    assign load_ok = rise_slot && have_data && at_end;
    assign take    = load_ok;

    // Move the line on each rise slot: load a byte, shift, or go idle.
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            mode   <= TXS_IDLE;
            shreg  <= '0;
            bitcnt <= '0;
            txd    <= 1'b0;
            fs     <= 1'b0;
            oe_n   <= 1'b1;
        end else if (rise_slot) begin
            if (load_ok) begin
                mode   <= TXS_SHIFT;
                txd    <= byte_in[W-1];
                shreg  <= byte_in << 1;
                bitcnt <= '0;
                fs     <= 1'b1;
                oe_n   <= 1'b0;
            end else if (!at_end) begin
                txd    <= shreg[W-1];
                shreg  <= shreg << 1;
                bitcnt <= bitcnt + 1'b1;
                fs     <= 1'b0;
            end else begin
                mode   <= TXS_IDLE;
                txd    <= 1'b0;
                fs     <= 1'b0;
                oe_n   <= 1'b1;
            end
        end
    end

    // R3: outside a rise slot the data line holds its value.
    a_r3_txd_hold: assert property (@(posedge clk) disable iff (!clr_n)
        !rise_slot |=> $stable(txd));

    // R4: a frame pulse lasts exactly two bus cycles.
    a_r4_fs_width: assert property (@(posedge clk) disable iff (!clr_n)
        $rose(fs) |=> (fs ##1 !fs));

    // R5: an idle line carries no data and no frame pulse.
    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!clr_n)
        oe_n |-> (!txd && !fs));

endmodule

// File: rtl/ss_rx.sv
// Deserializer. On each sample slot (falling serial clock) it takes one bit.
// A bit taken while the frame input is high starts a new byte. When a byte
// is complete it gives a one-cycle push pulse with the assembled word.
// Assumes the incoming serial clock is aligned with the bus clock.
module ss_rx #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         sample_slot,
    input  logic         fs_in,
    input  logic         rxd,
    output logic         push,
    output logic [W-1:0] word
);
    localparam int BW = (W > 1) ? $clog2(W) : 1;
    localparam logic [BW-1:0] LASTBIT = BW'(W - 1);

    logic [W-1:0]  shreg;
    logic [BW-1:0] got;

    // Collect bits and emit a finished word.
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            shreg <= '0;
            got   <= '0;
            push  <= 1'b0;
            word  <= '0;
        end else begin
            push <= 1'b0;
            if (sample_slot) begin
                if (fs_in) begin
                    shreg <= {{(W-1){1'b0}}, rxd};
                    got   <= BW'(1);
                end else if (got == LASTBIT) begin
                    word  <= {shreg[W-2:0], rxd};
                    push  <= 1'b1;
                    got   <= '0;
                end else if (got != '0) begin
                    shreg <= {shreg[W-2:0], rxd};
                    got   <= got + 1'b1;
                end
            end
        end
    end

    // R8: a finished word is reported only right after a sample slot.
    a_r8_push_after_sample: assert property (@(posedge clk) disable iff (!clr_n)
        push |-> $past(sample_slot));

endmodule

// File: rtl/sserial_port.sv
// Serial port top. Host writes go into the transmit queue, and host reads
// take from the receive queue. Makes a serial clock at half the bus rate,
// serializes queued bytes, and deserializes incoming frames.
// Assumes sclk_in is the same signal as sclk_out or aligned with it.
module sserial_port #(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              host_sel,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              tx_full_irq,
    output logic              sclk_out,
    output logic              fs_out,
    output logic              txd_oe_n,
    output logic              txd,
    input  logic              sclk_in,
    input  logic              fs_in,
    input  logic              rxd
);
    logic              sclk_r;
    logic              tx_push, tx_take, tx_full, tx_empty;
    logic [DATA_W-1:0] tx_head;
    logic              rx_pop, rx_full, rx_empty, rx_done, rx_push;
    logic [DATA_W-1:0] rx_head, rx_word;

    assign tx_push     = host_sel && host_wr;
    assign rx_pop      = host_sel && !host_wr;
    assign rx_push     = rx_done && !rx_full;
    assign tx_full_irq = tx_full;
    assign sclk_out    = sclk_r;

    // Divide the bus clock by two to make the serial clock.
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            sclk_r <= 1'b0;
        end else begin
            sclk_r <= !sclk_r;
        end
    end

    // Show the oldest received byte when the host reads it.
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            host_rdata <= '0;
        end else if (rx_pop && !rx_empty) begin
            host_rdata <= rx_head;
        end
    end

    ss_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) i_tx_q (
        .clk       (clk),
        .clr_n     (clr_n),
        .push      (tx_push),
        .push_data (host_wdata),
        .pop       (tx_take),
        .head      (tx_head),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    ss_tx #(.W(DATA_W)) i_tx (
        .clk       (clk),
        .clr_n     (clr_n),
        .rise_slot (!sclk_r),
        .have_data (!tx_empty),
        .byte_in   (tx_head),
        .take      (tx_take),
        .txd       (txd),
        .fs        (fs_out),
        .oe_n      (txd_oe_n)
    );

    ss_rx #(.W(DATA_W)) i_rx (
        .clk         (clk),
        .clr_n       (clr_n),
        .sample_slot (sclk_in),
        .fs_in       (fs_in),
        .rxd         (rxd),
        .push        (rx_done),
        .word        (rx_word)
    );

    ss_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) i_rx_q (
        .clk       (clk),
        .clr_n     (clr_n),
        .push      (rx_push),
        .push_data (rx_word),
        .pop       (rx_pop),
        .head      (rx_head),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    // R2: the serial clock inverts on every bus clock edge.
    a_r2_sclk_toggle: assert property (@(posedge clk) disable iff (!clr_n)
        sclk_out |=> !sclk_out);

    // R11: without select the read data does not move.
    a_r11_no_sel_hold: assert property (@(posedge clk) disable iff (!clr_n)
        !host_sel |=> $stable(host_rdata));

endmodule

// File: tb/test_sserial_port.sv
module test_sserial_port;

    logic       clk = 1'b0;
    logic       clr_n;
    logic       host_sel, host_wr;
    logic [7:0] host_wdata, host_rdata;
    logic       tx_full_irq, sclk_out, fs_out, txd_oe_n, txd;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    logic done = 1'b0;

    // Stimulus table: byte written; in loopback the same byte is expected back.
    localparam logic [7:0] VEC [6] = '{8'hA5, 8'h80, 8'h01, 8'hFF, 8'h3C, 8'h00};

    always #10 clk = !clk;   // 50 MHz

    sserial_port i_sserial_port (
        .clk         (clk),
        .clr_n       (clr_n),
        .host_sel    (host_sel),
        .host_wr     (host_wr),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .tx_full_irq (tx_full_irq),
        .sclk_out    (sclk_out),
        .fs_out      (fs_out),
        .txd_oe_n    (txd_oe_n),
        .txd         (txd),
        .sclk_in     (sclk_out),
        .fs_in       (fs_out),
        .rxd         (txd)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Line monitor: decodes txd and counts protocol errors.
    logic       mon_en = 1'b0;
    logic       p_sclk = 1'b0, p_txd = 1'b0, p_fs = 1'b0;
    int         nb = 0;
    logic [7:0] val = 8'h00;
    int         mon_n = 0;
    logic [7:0] mon_byte [64];
    int         mon_start [64];
    int         cur_start = 0;
    int         e_r2 = 0, e_r3 = 0, e_r4 = 0, e_r5 = 0;

    always @(negedge clk) begin
        if (mon_en) begin
            if (sclk_out == p_sclk) e_r2++;
            if (txd_oe_n && (txd || fs_out)) e_r5++;
            if (!sclk_out) begin
                if (txd !== p_txd || fs_out !== p_fs) e_r3++;
            end else if (!txd_oe_n) begin
                if (fs_out) begin
                    if (nb != 0 && nb != 8) e_r4++;
                    val = {7'b0, txd};
                    nb = 1;
                    cur_start = cyc;
                end else begin
                    if (nb == 0 || nb == 8) e_r4++;
                    val = {val[6:0], txd};
                    nb++;
                end
                if (nb == 8 && mon_n < 64) begin
                    mon_byte[mon_n]  = val;
                    mon_start[mon_n] = cur_start;
                    mon_n++;
                end
            end else begin
                if (nb != 0 && nb != 8) e_r5++;
                nb = 0;
            end
        end
        p_sclk = sclk_out;
        p_txd  = txd;
        p_fs   = fs_out;
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        if (cyc == 20000 && !done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=<%0d", cyc, 20000);
            summary();
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] d);
        host_sel = 1'b1; host_wr = 1'b1; host_wdata = d;
        @(negedge clk);
        host_sel = 1'b0; host_wr = 1'b0;
    endtask

    task automatic bus_read();
        host_sel = 1'b1; host_wr = 1'b0;
        @(negedge clk);
        host_sel = 1'b0;
    endtask

    initial begin
        int base;
        logic [7:0] last;
        clr_n = 1'b0; host_sel = 1'b0; host_wr = 1'b0; host_wdata = 8'h00;
        idle(4);
        // R1: cleared state
        check("R1 sclk_out", sclk_out, 0);
        check("R1 fs_out", fs_out, 0);
        check("R1 txd", txd, 0);
        check("R1 txd_oe_n", txd_oe_n, 1);
        check("R1 host_rdata", host_rdata, 0);
        check("R1 tx_full_irq", tx_full_irq, 0);
        clr_n = 1'b1;
        idle(2);
        mon_en = 1'b1;
        idle(4);

        // Table walk: R3 bit order on the line, R8 loopback read
        for (int k = 0; k < 6; k++) begin
            base = mon_n;
            bus_write(VEC[k]);
            idle(40);
            check("R3 bytes on line", mon_n, base + 1);
            check("R3 line byte", mon_byte[base], VEC[k]);
            bus_read();
            check("R8 read back", host_rdata, VEC[k]);
        end
        last = VEC[5];

        // R11: no select, write strobe and data ignored
        base = mon_n;
        host_sel = 1'b0; host_wr = 1'b1; host_wdata = 8'h66;
        idle(40);
        host_wr = 1'b0;
        check("R11 nothing sent", mon_n, base);
        check("R11 rdata held", host_rdata, last);
        // R9: read from empty queue holds the data
        host_wdata = 8'h00;
        bus_read();
        idle(2);
        check("R9 empty read holds", host_rdata, last);

        // Burst: R7 full flag and drop, R6 back to back, R10 receive overflow
        base = mon_n;
        bus_write(8'hC1);
        while (txd_oe_n) @(negedge clk);
        bus_write(8'hC2);
        bus_write(8'hC3);
        bus_write(8'hC4);
        check("R7 not full at three", tx_full_irq, 0);
        bus_write(8'hC5);
        check("R7 irq at four", tx_full_irq, 1);
        bus_write(8'hEE);
        check("R7 irq stays after drop", tx_full_irq, 1);
        idle(120);
        check("R7 fifth write dropped", mon_n, base + 5);
        check("R7 irq cleared", tx_full_irq, 0);
        for (int k = 1; k < 5; k++) begin
            check("R6 frame spacing", mon_start[base + k] - mon_start[base + k - 1], 16);
        end
        check("R7 last line byte", mon_byte[base + 4], 8'hC5);
        bus_read(); check("R10 read 1", host_rdata, 8'hC1);
        bus_read(); check("R10 read 2", host_rdata, 8'hC2);
        bus_read(); check("R10 read 3", host_rdata, 8'hC3);
        bus_read(); check("R10 read 4", host_rdata, 8'hC4);
        bus_read(); check("R9 R10 fifth read holds", host_rdata, 8'hC4);

        // Line monitor results
        check("R2 sclk toggle errors", e_r2, 0);
        check("R3 change outside rise errors", e_r3, 0);
        check("R4 frame pulse errors", e_r4, 0);
        check("R5 enable/idle errors", e_r5, 0);

        done = 1'b1;
        summary();
    end

endmodule